// File: doc/BRIEF.md
# Infrared Carrier Burst Transmitter

This block drives one infrared remote-control output. A carrier generator makes a square wave from programmable high and low durations. It can use either of two duration sets, a primary and an alternate. A burst sequencer counts a 12-bit on-interval (mark) and a 12-bit off-interval (space), and uses them to gate the carrier into bursts. Software programs it through a small byte-wide register bus. Every timing step advances only on cycles where the clock-enable input is high.

Three operating variants are selectable. In timed mode the carrier is sent during the mark and the line is silent during the space. In shift-keyed mode the space sends the alternate carrier instead of silence. In baseband mode there is no carrier: the line is a plain high mark and a low space. Two further controls change the timing. A half-rate prescaler slows the burst sequencer. A space-hold control keeps the line in space until software releases it. New mark and space lengths are written into buffers and take effect only when a full mark-plus-space cycle ends. At that point an end-of-cycle flag is raised, and it can drive the interrupt line.

The sequencer has four states:
- `M_IDLE`: the output is low.
- `M_MARK`: the mark interval.
- `M_SPACE`: the space interval.
- `M_HOLD`: the extended space.

It moves between them as follows:
- IDLE→MARK when enabled, latching the buffers.
- MARK→SPACE when the mark count is reached.
- SPACE→MARK when the space count is reached, unless the hold is set. This ends the cycle, latches the buffers and raises the flag.
- SPACE→HOLD when the space count is reached with the hold set. This also ends the cycle.
- HOLD→MARK when the hold is cleared.
- Any state→IDLE when the enable is cleared.

The carrier has two phases, high and low. Its counter restarts in the high phase on every sequencer state change.

Top module: `ir_carrier_tx`

## Requirements
- R1: After reset every register reads 0, `ir_out` is 0 and `eoc_irq` is 0.
- R2: Register map, byte addresses:
  - 0: control. bit0 enable, bit1 baseband, bit2 shift-keyed, bit3 half-rate, bit4 space-hold, bit5 interrupt enable.
  - 1: status. bit0 end-of-cycle flag, cleared by writing 1.
  - 2 / 3: primary carrier high / low time.
  - 4 / 5: alternate carrier high / low time.
  - 6: mark[11:4].
  - 7: mark[3:0] in bits 7:4 and space[11:8] in bits 3:0.
  - 8: space[7:0].
  
  All registers read back what was written.
- R3: In baseband mode the output is high for exactly mark sequencer steps and low for exactly space sequencer steps.
- R4: In timed mode each mark starts with the carrier high. The carrier is then high for the primary high time and low for the primary low time, counted in enabled cycles. The space is low.
- R5: In shift-keyed mode the space carries the alternate carrier, starting high, with the alternate high and low times.
- R6: A carrier time of 0 acts as 1, and a mark or space length of 0 acts as 1.
- R7: With half-rate set, the sequencer steps every second enabled cycle, doubling mark and space durations. The carrier rate is unchanged.
- R8: Writes to the mark/space buffers do not affect the cycle in progress; they apply from the next mark.
- R9: With space-hold set at a cycle end, the output stays in space and no mark begins until the bit is cleared. The next mark then runs its full length.
- R10: Each cycle end sets the status flag. `eoc_irq` equals flag AND interrupt enable.
- R11: All timing advances only in cycles where `clk_en` is 1.
- R12: Clearing enable returns the output to 0 within two cycles. Re-enabling starts a fresh full mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Timing step enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ir_out | output | 1 | Modulated infrared output |
| eoc_irq | output | 1 | End-of-cycle interrupt |

## Verification
The output is measured as run lengths of equal levels, sampled each cycle. Each mode is driven with its own pattern, and each pattern separates one kind of fault:
- A baseband burst with unequal mark and space exposes swapped or mis-packed fields.
- A timed burst with unequal carrier high and low times shows which register set is in use, and that the carrier restarts high.
- A shift-keyed burst uses alternate times different from the primary ones, so a missing set switch shows up as a wrong run length.
- Zero carrier times give a toggle every cycle.

The second cycle of a burst is measured under both the half-rate prescaler and a toggling clock enable, so both must double the durations. Buffer writes made mid-mark must leave the current space intact. A space-hold run of 40 cycles must stay low, and the interrupt follows the flag and its enable.

// File: rtl/ircmt_pkg.sv
package ircmt_pkg;

    localparam int REG_W  = 8;
    localparam int MS_W   = 12;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_P_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] A_P_LO  = 4'd3;
    localparam logic [ADDR_W-1:0] A_S_HI  = 4'd4;
    localparam logic [ADDR_W-1:0] A_S_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MS_0  = 4'd6;
    localparam logic [ADDR_W-1:0] A_MS_1  = 4'd7;
    localparam logic [ADDR_W-1:0] A_MS_2  = 4'd8;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_MARK  = 2'd1,
        M_SPACE = 2'd2,
        M_HOLD  = 2'd3
    } mod_state_t;

    typedef struct packed {
        logic irq_en;
        logic hold;
        logic half;
        logic fsk;
        logic bband;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ircmt_regs.sv
module ircmt_regs
    import ircmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic                 eoc_pulse,
    output ctrl_t                ctrl,
    output logic [REG_W-1:0]     p_hi,
    output logic [REG_W-1:0]     p_lo,
    output logic [REG_W-1:0]     s_hi,
    output logic [REG_W-1:0]     s_lo,
    output logic [MS_W-1:0]      mark_buf,
    output logic [MS_W-1:0]      space_buf,
    output logic                 eoc_irq
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            p_hi      <= '0;
            p_lo      <= '0;
            s_hi      <= '0;
            s_lo      <= '0;
            mark_buf  <= '0;
            space_buf <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_P_HI: p_hi <= bus_wdata;
                A_P_LO: p_lo <= bus_wdata;
                A_S_HI: s_hi <= bus_wdata;
                A_S_LO: s_lo <= bus_wdata;
                A_MS_0: mark_buf[11:4] <= bus_wdata;
                A_MS_1: begin
                    mark_buf[3:0]   <= bus_wdata[7:4];
                    space_buf[11:8] <= bus_wdata[3:0];
                end
                A_MS_2: space_buf[7:0] <= bus_wdata;
                default: ;
            endcase
        end
    end

    // flag: set by cycle end, cleared by writing 1 to status bit0; set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (eoc_pulse)
            flag_q <= 1'b1;
        else if (bus_wr && bus_addr == A_STAT && bus_wdata[0])
            flag_q <= 1'b0;
    end

    assign eoc_irq = flag_q & ctrl.irq_en;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
            A_STAT: bus_rdata = {{(REG_W-1){1'b0}}, flag_q};
            A_P_HI: bus_rdata = p_hi;
            A_P_LO: bus_rdata = p_lo;
            A_S_HI: bus_rdata = s_hi;
            A_S_LO: bus_rdata = s_lo;
            A_MS_0: bus_rdata = mark_buf[11:4];
            A_MS_1: bus_rdata = {mark_buf[3:0], space_buf[11:8]};
            A_MS_2: bus_rdata = space_buf[7:0];
            default: bus_rdata = '0;
        endcase
    end

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(eoc_pulse));

endmodule

// File: rtl/ircmt_carrier.sv
module ircmt_carrier
    import ircmt_pkg::*;
#(
    parameter int CAR_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             run,
    input  logic             restart,
    input  logic             sel_alt,
    input  logic [CAR_W-1:0] p_hi,
    input  logic [CAR_W-1:0] p_lo,
    input  logic [CAR_W-1:0] s_hi,
    input  logic [CAR_W-1:0] s_lo,
    output logic             carrier
);

    logic             phase_q;
    logic [CAR_W-1:0] ccnt_q;
    logic [CAR_W-1:0] dur_raw;
    logic [CAR_W-1:0] dur_eff;

    always_comb begin
        if (sel_alt)
            dur_raw = phase_q ? s_hi : s_lo;
        else
            dur_raw = phase_q ? p_hi : p_lo;
        dur_eff = (dur_raw == '0) ? CAR_W'(1) : dur_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b1;
            ccnt_q  <= CAR_W'(1);
        end else if (!run || restart) begin
            phase_q <= 1'b1;
            ccnt_q  <= CAR_W'(1);
        end else if (clk_en) begin
            if (ccnt_q >= dur_eff) begin
                phase_q <= ~phase_q;
                ccnt_q  <= CAR_W'(1);
            end else begin
                ccnt_q  <= ccnt_q + CAR_W'(1);
            end
        end
    end

    assign carrier = phase_q;

    assert_restart_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> phase_q);

    assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ccnt_q != '0));

endmodule

// File: rtl/ircmt_modulator.sv
module ircmt_modulator
    import ircmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic            en,
    input  logic            half,
    input  logic            hold,
    input  logic [MS_W-1:0] mark_buf,
    input  logic [MS_W-1:0] space_buf,
    output mod_state_t      state,
    output logic            restart,
    output logic            eoc_pulse
);

    mod_state_t      st_q, st_d;
    logic [MS_W-1:0] cnt_q;
    logic [MS_W-1:0] mark_w_q, space_w_q;
    logic [MS_W-1:0] mark_eff, space_eff;
    logic            pre_q;
    logic            tick;
    logic            load;

    assign mark_eff  = (mark_w_q  == '0) ? MS_W'(1) : mark_w_q;
    assign space_eff = (space_w_q == '0) ? MS_W'(1) : space_w_q;

    // half-rate prescaler: a step on every second enabled cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= 1'b0;
        else if (!half)
            pre_q <= 1'b0;
        else if (clk_en)
            pre_q <= ~pre_q;
    end

    assign tick = clk_en && (!half || pre_q);

    // next state and transition strobes
    always_comb begin
        st_d      = st_q;
        restart   = 1'b0;
        eoc_pulse = 1'b0;
        load      = 1'b0;
        if (!en) begin
            st_d = M_IDLE;
        end else begin
            unique case (st_q)
                M_IDLE: begin
                    st_d    = M_MARK;
                    restart = 1'b1;
                    load    = 1'b1;
                end
                M_MARK: begin
                    if (tick && cnt_q >= mark_eff) begin
                        st_d    = M_SPACE;
                        restart = 1'b1;
                    end
                end
                M_SPACE: begin
                    if (tick && cnt_q >= space_eff) begin
                        st_d      = hold ? M_HOLD : M_MARK;
                        restart   = 1'b1;
                        load      = 1'b1;
                        eoc_pulse = 1'b1;
                    end
                end
                M_HOLD: begin
                    if (!hold) begin
                        st_d    = M_MARK;
                        restart = 1'b1;
                    end
                end
                default: st_d = M_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= M_IDLE;
        else
            st_q <= st_d;
    end

    // interval counter and working lengths
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= MS_W'(1);
            mark_w_q  <= '0;
            space_w_q <= '0;
        end else begin
            if (restart)
                cnt_q <= MS_W'(1);
            else if (tick && (st_q == M_MARK || st_q == M_SPACE))
                cnt_q <= cnt_q + MS_W'(1);
            if (load) begin
                mark_w_q  <= mark_buf;
                space_w_q <= space_buf;
            end
        end
    end

    assign state = st_q;

    assert_half_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (half && tick) |=> (!tick || !half));

    assert_hold_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == M_HOLD && hold && en) |=> (st_q == M_HOLD));

    assert_mark_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == M_MARK) |=> ($stable(mark_w_q) && $stable(space_w_q)));

    assert_mark_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == M_MARK) |-> (cnt_q <= mark_eff));

    assert_gated_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && st_q == M_MARK && en) |=> (st_q == M_MARK && $stable(cnt_q)));

endmodule

// File: rtl/ir_carrier_tx.sv
module ir_carrier_tx
    import ircmt_pkg::*;
#(
    parameter int CAR_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              ir_out,
    output logic              eoc_irq
);

    ctrl_t            ctrl;
    logic [REG_W-1:0] p_hi, p_lo, s_hi, s_lo;
    logic [MS_W-1:0]  mark_buf, space_buf;
    mod_state_t       state;
    logic             restart, eoc_pulse;
    logic             carrier;
    logic             in_space;

    ircmt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eoc_pulse (eoc_pulse),
        .ctrl      (ctrl),
        .p_hi      (p_hi),
        .p_lo      (p_lo),
        .s_hi      (s_hi),
        .s_lo      (s_lo),
        .mark_buf  (mark_buf),
        .space_buf (space_buf),
        .eoc_irq   (eoc_irq)
    );

    ircmt_modulator u_mod (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .en        (ctrl.en),
        .half      (ctrl.half),
        .hold      (ctrl.hold),
        .mark_buf  (mark_buf),
        .space_buf (space_buf),
        .state     (state),
        .restart   (restart),
        .eoc_pulse (eoc_pulse)
    );

    assign in_space = (state == M_SPACE) || (state == M_HOLD);

    ircmt_carrier #(.CAR_W(CAR_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .run     (ctrl.en && !ctrl.bband),
        .restart (restart),
        .sel_alt (ctrl.fsk && in_space),
        .p_hi    (p_hi[CAR_W-1:0]),
        .p_lo    (p_lo[CAR_W-1:0]),
        .s_hi    (s_hi[CAR_W-1:0]),
        .s_lo    (s_lo[CAR_W-1:0]),
        .carrier (carrier)
    );

    // output process
    always_comb begin
        unique case (state)
            M_IDLE:  ir_out = 1'b0;
            M_MARK:  ir_out = ctrl.bband ? 1'b1 : carrier;
            M_SPACE,
            M_HOLD:  ir_out = (ctrl.fsk && !ctrl.bband) ? carrier : 1'b0;
            default: ir_out = 1'b0;
        endcase
    end

    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en) |=> !ir_out);

endmodule

// File: tb/ir_carrier_tx_test.sv
`timescale 1ns/1ps
module ir_carrier_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ir_out;
    logic       eoc_irq;

    int checks = 0;
    int errors = 0;
    logic gate_mode = 1'b0;

    localparam logic [7:0] C_EN   = 8'h01;
    localparam logic [7:0] C_BB   = 8'h02;
    localparam logic [7:0] C_FSK  = 8'h04;
    localparam logic [7:0] C_HALF = 8'h08;
    localparam logic [7:0] C_HOLD = 8'h10;
    localparam logic [7:0] C_IRQ  = 8'h20;

    always #4 clk = ~clk;

    ir_carrier_tx uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ir_out(ir_out), .eoc_irq(eoc_irq)
    );

    always @(negedge clk) clk_en <= gate_mode ? ~clk_en : 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ms(input logic [11:0] m, input logic [11:0] s);
        wr(4'd6, m[11:4]);
        wr(4'd7, {m[3:0], s[11:8]});
        wr(4'd8, s[7:0]);
    endtask

    task automatic wait_level(input logic lvl);
        for (int i = 0; i < 400 && ir_out !== lvl; i++) @(negedge clk);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (ir_out === lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stop_all();
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h01);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 9; a++) begin
            rd(a[3:0], d);
            chk("R1 reg reset", d, 0);
        end
        chk("R1 ir_out reset", ir_out, 0);
        chk("R1 irq reset", eoc_irq, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        set_ms(12'hABC, 12'hDEF);
        rd(4'd6, d); chk("R2 ms0", d, 8'hAB);
        rd(4'd7, d); chk("R2 ms1", d, 8'hCD);
        rd(4'd8, d); chk("R2 ms2", d, 8'hEF);
        wr(4'd4, 8'h5A); rd(4'd4, d); chk("R2 alt hi", d, 8'h5A);
        wr(4'd0, C_HOLD | C_IRQ); rd(4'd0, d); chk("R2 ctrl", d, 8'h30);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_baseband();
        int n; logic [7:0] d;
        set_ms(12'd3, 12'd5);
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R3 baseband mark", n, 3);
        run_len(1'b0, n); chk("R3 baseband space", n, 5);
        rd(4'd1, d); chk("R10 flag after cycle", d[0], 1);
        chk("R10 irq masked", eoc_irq, 0);
        wr(4'd0, C_IRQ);
        @(negedge clk); chk("R10 irq enabled", eoc_irq, 1);
        chk("R12 disabled output low", ir_out, 0);
        wr(4'd1, 8'h01);
        rd(4'd1, d); chk("R10 flag cleared", d[0], 0);
        chk("R10 irq cleared", eoc_irq, 0);
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R12 re-enable full mark", n, 3);
        stop_all();
    endtask

    task automatic t_timed();
        int n;
        wr(4'd2, 8'd2); wr(4'd3, 8'd3);
        wr(4'd4, 8'd7); wr(4'd5, 8'd7);
        set_ms(12'd12, 12'd8);
        wr(4'd0, C_EN);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R4 carrier high 1", n, 2);
        run_len(1'b0, n); chk("R4 carrier low 1", n, 3);
        run_len(1'b1, n); chk("R4 carrier high 2", n, 2);
        run_len(1'b0, n); chk("R4 carrier low 2", n, 3);
        run_len(1'b1, n); chk("R4 carrier high 3", n, 2);
        run_len(1'b0, n); chk("R4 silent space", n, 8);
        run_len(1'b1, n); chk("R4 next mark starts high", n, 2);
        stop_all();
    endtask

    task automatic t_fsk();
        int n;
        wr(4'd2, 8'd2); wr(4'd3, 8'd2);
        wr(4'd4, 8'd3); wr(4'd5, 8'd3);
        set_ms(12'd4, 12'd6);
        wr(4'd0, C_EN | C_FSK);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R5 mark high", n, 2);
        run_len(1'b0, n); chk("R5 mark low", n, 2);
        run_len(1'b1, n); chk("R5 alt high", n, 3);
        run_len(1'b0, n); chk("R5 alt low", n, 3);
        run_len(1'b1, n); chk("R5 back to primary", n, 2);
        stop_all();
    endtask

    task automatic t_zero();
        int n;
        wr(4'd2, 8'd0); wr(4'd3, 8'd0);
        set_ms(12'd6, 12'd4);
        wr(4'd0, C_EN);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R6 zero high", n, 1);
        run_len(1'b0, n); chk("R6 zero low", n, 1);
        run_len(1'b1, n); chk("R6 zero high again", n, 1);
        stop_all();
        set_ms(12'd0, 12'd2);
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R6 zero mark", n, 1);
        stop_all();
    endtask

    task automatic t_half();
        int n;
        set_ms(12'd3, 12'd2);
        wr(4'd0, C_EN | C_BB | C_HALF);
        wait_level(1'b1);
        run_len(1'b1, n);
        run_len(1'b0, n); chk("R7 half space", n, 4);
        run_len(1'b1, n); chk("R7 half mark", n, 6);
        stop_all();
    endtask

    task automatic t_gate();
        int n;
        set_ms(12'd3, 12'd2);
        gate_mode = 1'b1;
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        run_len(1'b1, n);
        run_len(1'b0, n); chk("R11 gated space", n, 4);
        run_len(1'b1, n); chk("R11 gated mark", n, 6);
        gate_mode = 1'b0;
        stop_all();
    endtask

    task automatic t_dbuf();
        int n;
        set_ms(12'd10, 12'd10);
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        set_ms(12'd5, 12'd2);
        wait_level(1'b0);
        run_len(1'b0, n); chk("R8 old space kept", n, 10);
        run_len(1'b1, n); chk("R8 new mark", n, 5);
        run_len(1'b0, n); chk("R8 new space", n, 2);
        stop_all();
    endtask

    task automatic t_hold();
        int n; int highs; logic [7:0] d;
        set_ms(12'd2, 12'd6);
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        wr(4'd0, C_EN | C_BB | C_HOLD);
        wait_level(1'b0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ir_out) highs++;
        end
        chk("R9 held in space", highs, 0);
        rd(4'd1, d); chk("R9 cycle end flagged", d[0], 1);
        wr(4'd0, C_EN | C_BB);
        wait_level(1'b1);
        run_len(1'b1, n); chk("R9 mark after release", n, 2);
        stop_all();
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_baseband();
        t_timed();
        t_fsk();
        t_zero();
        t_half();
        t_gate();
        t_dbuf();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule